// File: doc/BRIEF.md
# Prescaled Timer Pair

Two independent 8-bit down-counting timers. Each one is fed through its own 6-bit prescaler and raises a single-cycle interrupt pulse when its count runs out. Each timer can stop at the end of its count or reload and keep running. Software programs the block through a small write-only register port. That port sets the initial values, the divisors, the run and load controls, and the routing options. Both live counts are always visible on output ports.

The first timer always counts an internal tick, which is the system clock divided by four. The second timer can count the same tick. It can also take its input from one external pin, which is synchronised and edge-detected on its rising edge, or from the first timer's end-of-count pulses when the two are chained. A single timer output line can follow either timer, show the internal tick clock, or be held low.

Register map (3-bit address, 8-bit data): 0 = control, 1 = timer A initial value, 2 = timer A setup, 3 = timer B initial value, 4 = timer B setup, 5 = routing.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous reset, both counts read 0, both interrupt pulses and the timer output are low, and neither timer counts until it is loaded and started.
- R2: The prescaler divisor is setup bits [5:0] (address 2 or 4). The values 1 to 63 divide by that value, and 0 divides by 64. One count step takes 4 x divisor clock cycles on the internal tick.
- R3: The initial value (address 1 or 3) covers 1 to 255 directly, and 0 means 256. In reload mode the interrupt period is 4 x divisor x initial-value cycles.
- R4: irq0 (timer A) and irq1 (timer B) are one-cycle pulses, issued when the count steps from 1 to its end.
- R5: With setup bit 7 = 0 (single pass), a timer stops at 0 after its end of count. It then reads 0 and issues no further pulse until it is loaded again.
- R6: With setup bit 7 = 1 (reload), the count returns to the initial value at each end of count and keeps running.
- R7: In a control write (address 0), bit 0 loads timer A and bit 2 loads timer B. A load copies the initial value into the count and restarts the prescaler. Bit 1 is the run enable for timer A and bit 3 for timer B. Clearing a run bit freezes the count, and setting it again resumes from the frozen value.
- R8: count0 and count1 present the live count at all times.
- R9: The routing register (address 5) holds the external mode in bits [1:0], the external source select in bit 2, the chain enable in bit 3 and the output select in bits [5:4]. With bit 2 = 1 and mode 00, each rising edge of ext_in is one prescaler input for timer B.
- R10: With mode 01 (gate), timer B counts internal ticks only while ext_in is high.
- R11: With mode 10 (one-shot trigger), a load leaves timer B waiting. A rising edge then reloads it and starts counting. Further edges are ignored until that count ends.
- R12: With mode 11 (retriggerable), every rising edge of ext_in reloads timer B and starts it counting.
- R13: With the chain bit set, timer B counts timer A's end-of-count pulses instead of ticks or ext_in.
- R14: The output select chooses what tout shows. 00 toggles tout at each timer A end of count, and 01 does the same for timer B. 10 shows the internal tick clock, which has a 4-cycle period. 11 holds tout low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ext_in | input | 1 | Asynchronous external input for timer B |
| count0 | output | 8 | Live count of timer A |
| count1 | output | 8 | Live count of timer B |
| irq0 | output | 1 | End-of-count pulse, timer A |
| irq1 | output | 1 | End-of-count pulse, timer B |
| tout | output | 1 | Selected timer output |

## Verification
Interrupt periods are measured for random divisor and initial-value pairs. Directed runs cover the zero encodings, where divide-by-64 and count-of-256 expose any off-by-one in the wrap logic. A long window of silence after a single-pass run distinguishes stopping from reloading. A pause-and-resume sequence tells a frozen count apart from a restarted one. For the external input, pulse trains are timed against the count. The last clock edge must be the one that fires, a low gate must freeze the count, and a second trigger edge must reload the count only in the retriggerable mode. The chained and output-select patterns tell which pulse source reaches timer B and tout.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_T0_INIT = 3'd1;
  localparam logic [ADDR_W-1:0] A_T0_CFG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_T1_INIT = 3'd3;
  localparam logic [ADDR_W-1:0] A_T1_CFG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ROUTE   = 3'd5;

  typedef enum logic [1:0] {
    EXT_CLOCK     = 2'b00,
    EXT_GATE      = 2'b01,
    EXT_TRIG_ONCE = 2'b10,
    EXT_TRIG_RE   = 2'b11
  } ext_mode_e;

  typedef enum logic [1:0] {
    OUT_T0   = 2'b00,
    OUT_T1   = 2'b01,
    OUT_TICK = 2'b10,
    OUT_LOW  = 2'b11
  } out_sel_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic tick_sq
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
  localparam logic [DW-1:0] HALF = DW'(TICK_DIV / 2 - 1);

  logic [DW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      tick    <= 1'b0;
      tick_sq <= 1'b0;
    end else begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
      tick  <= (phase == LAST);
      if (phase == LAST || phase == HALF)
        tick_sq <= ~tick_sq;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [PSC_W-1:0] div,
  output logic             pulse
);
  logic [PSC_W-1:0] acc;
  logic [PSC_W-1:0] limit;

  // a divisor of 0 wraps to all ones, giving the full 2**PSC_W division
  assign limit = div - PSC_W'(1);
  assign pulse = step && (acc == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc <= '0;
    else if (step)
      acc <= pulse ? '0 : acc + 1'b1;
  end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  input  logic             dec,
  input  logic             modulo,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             eoc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      eoc    <= 1'b0;
    end else if (load) begin
      cnt    <= init;
      active <= 1'b1;
      eoc    <= 1'b0;
    end else if (dec && active) begin
      if (cnt == CNT_W'(1)) begin
        eoc    <= 1'b1;
        cnt    <= modulo ? init : '0;
        active <= modulo;
      end else begin
        eoc <= 1'b0;
        cnt <= cnt - 1'b1;   // 0 - 1 wraps to the top: a zero load spans 2**CNT_W
      end
    end else begin
      eoc <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_t1_source.sv
module tmr_t1_source
  import timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  ext_mode_e mode,
  input  logic      use_ext,
  input  logic      cascade,
  input  logic      tick,
  input  logic      eoc0,
  input  logic      eoc1,
  input  logic      load,
  input  logic      ext_in,
  output logic      src,
  output logic      gate_ok,
  output logic      trig_load
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_d;
  logic                   lvl;
  logic                   rise;
  logic                   armed;
  logic                   ext_path;
  logic                   trig_mode;

  assign lvl = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign rise      = lvl && !lvl_d;
  assign ext_path  = use_ext && !cascade;
  assign trig_mode = ext_path && mode[1];
  assign trig_load = trig_mode && rise && (mode == EXT_TRIG_RE || !armed);

  always_ff @(posedge clk) begin
    if (rst || !trig_mode)
      armed <= 1'b0;
    else if (trig_load)
      armed <= 1'b1;
    else if (eoc1 || load)
      armed <= 1'b0;
  end

  always_comb begin
    if (cascade)
      src = eoc0;
    else if (ext_path && mode == EXT_CLOCK)
      src = rise;
    else
      src = tick;

    if (!ext_path)
      gate_ok = 1'b1;
    else if (mode == EXT_GATE)
      gate_ok = lvl;
    else if (trig_mode)
      gate_ok = armed;
    else
      gate_ok = 1'b1;
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import timer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 6,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_in,
  output logic [CNT_W-1:0]  count0,
  output logic [CNT_W-1:0]  count1,
  output logic              irq0,
  output logic              irq1,
  output logic              tout
);
  localparam int NCH = 2;

  logic [NCH-1:0]   run_q, load_stb, mod_v, eoc, active;
  logic [NCH-1:0]   src, gate_ok, chan_load, psc_pulse;
  logic [CNT_W-1:0] init_q [NCH];
  logic [PSC_W-1:0] div_q  [NCH];
  logic [CNT_W-1:0] cnt    [NCH];

  ext_mode_e ext_mode;
  out_sel_e  osel;
  logic      use_ext, cascade;
  logic      tick, tick_sq;
  logic      t1_src, t1_gate, trig_load;

  // register port
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      mod_v    <= '0;
      ext_mode <= EXT_CLOCK;
      osel     <= OUT_T0;
      use_ext  <= 1'b0;
      cascade  <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        init_q[i] <= '0;
        div_q[i]  <= '0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: for (int i = 0; i < NCH; i++) run_q[i] <= wr_data[2*i+1];
        A_T0_INIT: init_q[0] <= wr_data[CNT_W-1:0];
        A_T0_CFG: begin
          div_q[0] <= wr_data[PSC_W-1:0];
          mod_v[0] <= wr_data[DATA_W-1];
        end
        A_T1_INIT: init_q[1] <= wr_data[CNT_W-1:0];
        A_T1_CFG: begin
          div_q[1] <= wr_data[PSC_W-1:0];
          mod_v[1] <= wr_data[DATA_W-1];
        end
        A_ROUTE: begin
          ext_mode <= ext_mode_e'(wr_data[1:0]);
          use_ext  <= wr_data[2];
          cascade  <= wr_data[3];
          osel     <= out_sel_e'(wr_data[5:4]);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      load_stb[i] = wr_en && (wr_addr == A_CTRL) && wr_data[2*i];
  end

  tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick), .tick_sq(tick_sq)
  );

  tmr_t1_source #(.SYNC_STAGES(SYNC_STAGES)) u_t1src (
    .clk(clk), .rst(rst), .mode(ext_mode), .use_ext(use_ext),
    .cascade(cascade), .tick(tick), .eoc0(eoc[0]), .eoc1(eoc[1]),
    .load(load_stb[1]), .ext_in(ext_in),
    .src(t1_src), .gate_ok(t1_gate), .trig_load(trig_load)
  );

  always_comb begin
    src       = {t1_src, tick};
    gate_ok   = {t1_gate, 1'b1};
    chan_load = {load_stb[1] | trig_load, load_stb[0]};
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .clr(chan_load[i]),
        .step(src[i] & gate_ok[i] & run_q[i] & active[i]),
        .div(div_q[i]), .pulse(psc_pulse[i])
      );
      tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(chan_load[i]), .init(init_q[i]),
        .dec(psc_pulse[i]), .modulo(mod_v[i]),
        .cnt(cnt[i]), .active(active[i]), .eoc(eoc[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      tout <= 1'b0;
    else begin
      case (osel)
        OUT_T0:   if (eoc[0]) tout <= ~tout;
        OUT_T1:   if (eoc[1]) tout <= ~tout;
        OUT_TICK: tout <= tick_sq;
        default:  tout <= 1'b0;
      endcase
    end
  end

  assign count0 = cnt[0];
  assign count1 = cnt[1];
  assign irq0   = eoc[0];
  assign irq1   = eoc[1];
endmodule

// File: rtl/tmr_pair_checks.sv
module tmr_pair_checks #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             irq0,
  input logic             irq1,
  input logic [CNT_W-1:0] count0,
  input logic [CNT_W-1:0] count1,
  input logic             tout,
  input logic [1:0]       run_q,
  input logic [1:0]       load_stb,
  input logic [1:0]       mod_v,
  input logic [CNT_W-1:0] init0,
  input logic [1:0]       osel
);
  p_irq0_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    irq0 |=> !irq0);

  p_irq1_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    irq1 |=> !irq1);

  p_pause_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run_q[0] && !load_stb[0]) |=> $stable(count0));

  p_pause_hold1_r7: assert property (@(posedge clk) disable iff (rst)
    (!run_q[1] && !load_stb[1] && !irq0) |=> $stable(count1));

  p_single_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (irq0 && !mod_v[0] && $stable(mod_v[0])) |-> (count0 == '0));

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (irq0 && mod_v[0] && $stable(mod_v[0]) && $stable(init0)) |-> (count0 == init0));

  p_tout_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (osel == 2'b00 && !irq0 && !wr_en) |=> $stable(tout));

  p_tout_low_r14: assert property (@(posedge clk) disable iff (rst)
    (osel == 2'b11 && !wr_en) |=> !tout);
endmodule

bind tmr_pair tmr_pair_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq0(irq0), .irq1(irq1),
  .count0(count0), .count1(count1), .tout(tout),
  .run_q(run_q), .load_stb(load_stb), .mod_v(mod_v),
  .init0(init_q[0]), .osel(osel)
);

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;
  localparam int TICK = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext_in = 1'b0;
  logic [7:0] count0, count1;
  logic       irq0, irq1, tout;

  int cyc = 0, checks = 0, errors = 0;
  int n_irq0 = 0, n_irq1 = 0, t_irq0 = 0, t_irq1 = 0, n_tog = 0;
  logic tout_prev = 1'b0;

  tmr_pair uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_in(ext_in), .count0(count0), .count1(count1),
    .irq0(irq0), .irq1(irq1), .tout(tout)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (irq0) begin n_irq0 = n_irq0 + 1; t_irq0 = cyc; end
      if (irq1) begin n_irq1 = n_irq1 + 1; t_irq1 = cyc; end
      if (tout != tout_prev) n_tog = n_tog + 1;
    end
    tout_prev = tout;
  end

  function automatic int exp_period(input int p, input int n);
    return TICK * ((p == 0) ? 64 : p) * ((n == 0) ? 256 : n);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int ch, input int limit, output int stamp);
    int start;
    start = (ch == 0) ? n_irq0 : n_irq1;
    stamp = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (ch == 0 && n_irq0 > start) begin stamp = t_irq0; break; end
      if (ch == 1 && n_irq1 > start) begin stamp = t_irq1; break; end
    end
  endtask

  task automatic period(input int ch, input int limit, output int p);
    int a, b;
    wait_irq(ch, limit, a);
    wait_irq(ch, limit, b);
    p = (a < 0 || b < 0) ? -1 : b - a;
  endtask

  task automatic ext_pulse();
    ext_in = 1'b1; idle(4);
    ext_in = 1'b0; idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, n, per, v, v2, base, hold;
    void'($urandom(32'h1f2e3d4c));
    idle(5);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, nothing counts
    check(count0 == 0 && count1 == 0, "R1 counts after reset", count0 + count1, 0);
    check(!irq0 && !irq1 && !tout, "R1 outputs after reset", irq0 + irq1 + tout, 0);
    idle(50);
    check(n_irq0 == 0 && n_irq1 == 0 && count0 == 0, "R1 idle after reset", n_irq0 + n_irq1, 0);

    // R2 R3 R6: random reload periods on timer A
    for (int it = 0; it < 6; it++) begin
      p = $urandom_range(1, 8); n = $urandom_range(1, 20);
      wr(3'd1, 8'(n)); wr(3'd2, 8'h80 | 8'(p)); wr(3'd0, 8'h03);
      period(0, 3000, per);
      check(per == exp_period(p, n), "R3 R6 timer A reload period", per, exp_period(p, n));
    end
    // R2: zero divisor means 64
    wr(3'd1, 8'd1); wr(3'd2, 8'h80); wr(3'd0, 8'h03);
    period(0, 3000, per);
    check(per == exp_period(0, 1), "R2 divisor zero", per, exp_period(0, 1));
    // R3: zero initial value means 256
    wr(3'd1, 8'd0); wr(3'd2, 8'h81); wr(3'd0, 8'h03);
    period(0, 3000, per);
    check(per == exp_period(1, 0), "R3 initial zero", per, exp_period(1, 0));
    // R4: pulse width
    wr(3'd1, 8'd2); wr(3'd2, 8'h81); wr(3'd0, 8'h03);
    wait_irq(0, 100, v);
    check(!irq0, "R4 irq0 one cycle", irq0, 0);

    // R2: random reload periods on timer B, internal tick
    wr(3'd5, 8'h00); wr(3'd0, 8'h00);
    for (int it = 0; it < 3; it++) begin
      p = $urandom_range(1, 6); n = $urandom_range(1, 16);
      wr(3'd3, 8'(n)); wr(3'd4, 8'h80 | 8'(p)); wr(3'd0, 8'h0C);
      period(1, 3000, per);
      check(per == exp_period(p, n), "R2 timer B reload period", per, exp_period(p, n));
    end
    wr(3'd0, 8'h00);

    // R5: single pass stops at zero
    wr(3'd1, 8'd3); wr(3'd2, 8'h01); wr(3'd0, 8'h03);
    check(count0 == 3, "R7 load copies initial value", count0, 3);
    base = n_irq0;
    wait_irq(0, 200, v);
    idle(200);
    check(n_irq0 == base + 1, "R5 single pulse", n_irq0 - base, 1);
    check(count0 == 0, "R5 stops at zero", count0, 0);

    // R7 R8: pause and resume
    wr(3'd1, 8'd200); wr(3'd2, 8'h82); wr(3'd0, 8'h03);
    idle(60);
    v = count0;
    check(v >= 190 && v <= 199, "R8 live count", v, 193);
    wr(3'd0, 8'h00);
    hold = count0;
    idle(100);
    check(count0 == hold, "R7 paused count held", count0, hold);
    wr(3'd0, 8'h02);
    idle(40);
    check(count0 < hold && count0 > hold - 8, "R7 resume from held value", count0, hold - 5);
    wr(3'd0, 8'h00);

    // R9: external clock
    wr(3'd5, 8'h04); wr(3'd3, 8'd5); wr(3'd4, 8'h01); wr(3'd0, 8'h0C);
    base = n_irq1;
    for (int k = 0; k < 4; k++) ext_pulse();
    idle(6);
    check(n_irq1 == base && count1 == 1, "R9 four edges counted", count1, 1);
    ext_pulse(); idle(6);
    check(n_irq1 == base + 1 && count1 == 0, "R9 fifth edge ends count", n_irq1 - base, 1);

    // R10: gate
    wr(3'd5, 8'h05); wr(3'd3, 8'd100); wr(3'd4, 8'h81); wr(3'd0, 8'h0C);
    idle(80);
    check(count1 == 100, "R10 gate low holds", count1, 100);
    ext_in = 1'b1; idle(80); ext_in = 1'b0; idle(10);
    v = count1;
    check(100 - v >= 17 && 100 - v <= 23, "R10 gate high counts", 100 - v, 20);
    idle(60);
    check(count1 == v, "R10 gate low again holds", count1, v);

    // R11: one-shot trigger
    wr(3'd5, 8'h06); wr(3'd4, 8'h01); wr(3'd0, 8'h0C);
    idle(60);
    check(count1 == 100, "R11 waits for edge", count1, 100);
    ext_pulse(); idle(72);
    v = count1;
    check(v >= 75 && v <= 85, "R11 edge starts count", v, 80);
    ext_pulse();
    v2 = count1;
    check(v2 <= v && v2 < 90, "R11 second edge ignored", v2, v - 2);

    // R12: retriggerable
    wr(3'd5, 8'h07); wr(3'd0, 8'h0C);
    idle(40);
    check(count1 == 100, "R12 waits for edge", count1, 100);
    ext_pulse(); idle(72);
    v = count1;
    check(v >= 75 && v <= 85, "R12 edge starts count", v, 80);
    ext_pulse();
    v2 = count1;
    check(v2 >= 95, "R12 second edge reloads", v2, 98);

    // R13: chained
    wr(3'd5, 8'h08); wr(3'd1, 8'd2); wr(3'd2, 8'h81);
    wr(3'd3, 8'd3); wr(3'd4, 8'h81); wr(3'd0, 8'h0F);
    period(1, 500, per);
    check(per == 24, "R13 chained period", per, 24);

    // R14: output selection
    wr(3'd5, 8'h00); wr(3'd1, 8'd3); wr(3'd0, 8'h03);
    idle(30); base = n_tog; idle(240);
    check(n_tog - base >= 19 && n_tog - base <= 21, "R14 follows timer A", n_tog - base, 20);
    wr(3'd3, 8'd2); wr(3'd4, 8'h81); wr(3'd5, 8'h10); wr(3'd0, 8'h0C);
    idle(30); base = n_tog; idle(160);
    check(n_tog - base >= 19 && n_tog - base <= 21, "R14 follows timer B", n_tog - base, 20);
    wr(3'd5, 8'h20);
    idle(10); base = n_tog; idle(80);
    check(n_tog - base >= 39 && n_tog - base <= 41, "R14 tick clock", n_tog - base, 40);
    wr(3'd5, 8'h30);
    idle(3); base = n_tog; idle(50);
    check(n_tog == base && !tout, "R14 held low", n_tog - base, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule